// File: doc/BRIEF.md
# Escalating Watchdog with Reset Request

The block is a three-stage watchdog. It counts ticks of a timebase enable and, each time the selected period runs out, it takes one step of escalation. Two status bits hold the whole escalation state. The first step arms the watchdog. The second step raises the interrupt status. From then on, each step records a two-bit reset kind in status and pulses one of three reset-request outputs, or none. Software holds the watchdog at its early stages by clearing the two status bits with a write-one-to-clear before the next period runs out.

The control word holds three things: the period select, the reset kind and the interrupt enable. Writing it also triggers one escalation step at once, using the newly written values, and restarts the period. The reset controller that acts on the request pulses is not part of this block.

The escalation state machine has four states, named after the value of status bits [31:30]:
- `ST_QUIET` (00).
- `ST_FLAGGED` (01): only the interrupt status is set, which happens after software clears bit 31 alone.
- `ST_ARMED` (10).
- `ST_PENDING` (11).

On each step, the transitions are:
- QUIET→ARMED.
- FLAGGED→PENDING.
- ARMED→PENDING.
- PENDING→PENDING, which is also when the reset kind is recorded and the reset request fires.

Without a step, the only transitions are the clears made by software.

Top module: `wdog_escalator`

## Requirements
- R1: After reset, every status bit is 0, the period select, reset kind and interrupt enable are all 0, and the interrupt and all three reset-request outputs are low.
- R2: A step occurs after every 2^(BASE_LOG + STEP_LOG·sel) timebase ticks counted since the last step. `sel` is control bits [31:30]. The default exponents for sel 0 to 3 are 17, 21, 25 and 29.
- R3: A step that finds status bits [31:30] at 00 or 01 sets bit 31.
- R4: A step that finds status bits [31:30] at 10 sets bit 30. The `wdog_irq` output is high exactly while status bit 30 and control bit 27 are both 1.
- R5: A step that finds status bits [31:30] at 11 loads status bits [29:28] from control bits [29:28]. In the cycle after that step, exactly one reset-request output pulses high for that kind: core for 1, chip for 2, system for 3. Kind 0 pulses no output.
- R6: A control write stores bits [31:27] and performs a step in the same cycle using the written values. It also restarts the period count from zero.
- R7: A status clear write with bit 31, 30, 29 or 28 set clears that status bit. When the clear falls in the same cycle as a step, bits 31 and 30 are cleared before the step reads them. A reset kind loaded by the step takes precedence over a clear of bits [29:28].
- R8: A cycle without a tick and without a control write leaves the period count unchanged, so no step occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tb_tick | input | 1 | Timebase tick enable |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word: [31:30] period select, [29:28] reset kind, [27] interrupt enable |
| stat_clr_we | input | 1 | Status clear strobe |
| stat_clr_data | input | 32 | Write-one-to-clear mask, using bits [31:28] |
| status_q | output | 32 | Status: [31] armed, [30] interrupt status, [29:28] recorded reset kind; all other bits 0 |
| wdog_irq | output | 1 | Watchdog interrupt |
| rst_req_core | output | 1 | Single-cycle core reset request |
| rst_req_chip | output | 1 | Single-cycle chip reset request |
| rst_req_sys | output | 1 | Single-cycle system reset request |

## Verification
Two pairs of events can land in the same cycle:
- A period expiry and a software status clear. Whether the clear counts depends on the clear-before-step rule.
- A period expiry and a control write. These must produce a single step, not two.

The bench provokes the first pair by holding the clear strobe high across several expiries and by clearing at intervals just shorter than the period. It provokes the second pair with back-to-back control writes while ticks run. A behavioural model steps once per clock. Its status, interrupt and pulse values are compared with the outputs every cycle, so a coincidence handled in the wrong order shows up as a mismatch in the status bits or as a missing or doubled reset pulse.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    // Escalation state is the status pair [31:30] itself
    typedef enum logic [1:0] {
        ST_QUIET   = 2'b00,
        ST_FLAGGED = 2'b01,
        ST_ARMED   = 2'b10,
        ST_PENDING = 2'b11
    } wdg_state_e;

    typedef enum logic [1:0] {
        RK_NONE = 2'd0,
        RK_CORE = 2'd1,
        RK_CHIP = 2'd2,
        RK_SYS  = 2'd3
    } rst_kind_e;

    localparam int WORD_W    = 32;
    localparam int POS_SEL   = 30;  // control [31:30]
    localparam int POS_KIND  = 28;  // control/status [29:28]
    localparam int POS_IE    = 27;  // control [27]
    localparam int POS_ARMED = 31;  // status [31]
    localparam int POS_IRQST = 30;  // status [30]
    localparam int N_SEL     = 4;
    localparam int N_REQ     = 3;

endpackage

// File: rtl/wdg_ctrl_reg.sv
module wdg_ctrl_reg
    import wdg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [4:0] wr_field,   // control bits [31:27]
    output logic [1:0] held_sel,
    output logic       held_ie,
    output rst_kind_e  eff_kind,
    output logic       restart
);

    logic [1:0] in_sel;
    rst_kind_e  in_kind;
    logic       in_ie;
    rst_kind_e  held_kind;

    always_comb begin
        in_sel  = wr_field[4:3];
        in_kind = rst_kind_e'(wr_field[2:1]);
        in_ie   = wr_field[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_sel  <= 2'b00;
            held_kind <= RK_NONE;
            held_ie   <= 1'b0;
        end else if (wr_en) begin
            held_sel  <= in_sel;
            held_kind <= in_kind;
            held_ie   <= in_ie;
        end
    end

    // a write acts with its own values in the cycle it arrives
    assign eff_kind = wr_en ? in_kind : held_kind;
    assign restart  = wr_en;

    // R6
    ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (held_sel == $past(wr_field[4:3]) && held_ie == $past(wr_field[0])));

endmodule

// File: rtl/wdg_period.sv
module wdg_period
    import wdg_pkg::*;
#(
    parameter int CNT_W    = 30,
    parameter int BASE_LOG = 17,
    parameter int STEP_LOG = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       restart,
    input  logic [1:0] sel,
    output logic       expire
);

    localparam int TOP_LOG = BASE_LOG + STEP_LOG * (N_SEL - 1);
    localparam int HEADROOM = CNT_W - TOP_LOG;  // must not be negative

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] mask_tab [N_SEL];
    logic [CNT_W-1:0] mask;
    logic             at_top;

    for (genvar g = 0; g < N_SEL; g++) begin : g_mask
        localparam int LOGW = BASE_LOG + STEP_LOG * g;
        assign mask_tab[g] = {CNT_W{1'b1}} >> (CNT_W - LOGW);
    end

    assign mask   = mask_tab[sel];
    // carry out of the bit just below the selected position
    assign at_top = ((cnt & mask) == mask);
    assign expire = tick && !restart && at_top;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || expire) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R2
    cnt_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt & ~mask) == '0);

    // R8
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> cnt == $past(cnt));

endmodule

// File: rtl/wdg_escalate.sv
module wdg_escalate
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eval,
    input  logic             clr_armed,
    input  logic             clr_irqst,
    input  logic [1:0]       clr_kind,
    input  rst_kind_e        kind_in,
    output wdg_state_e       state,
    output rst_kind_e        kind_rec,
    output logic [N_REQ-1:0] req_vec
);

    wdg_state_e seen;
    wdg_state_e nxt;
    logic       fire;

    always_comb begin
        // software clear lands before the step looks at the state
        seen = wdg_state_e'({state[1] & ~clr_armed, state[0] & ~clr_irqst});
        nxt  = seen;
        fire = 1'b0;
        if (eval) begin
            unique case (seen)
                ST_QUIET:   nxt = ST_ARMED;
                ST_FLAGGED: nxt = ST_PENDING;
                ST_ARMED:   nxt = ST_PENDING;
                ST_PENDING: begin
                    nxt  = ST_PENDING;
                    fire = 1'b1;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_QUIET;
        else        state <= nxt;
    end

    // outputs: recorded kind and request pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_rec <= RK_NONE;
            req_vec  <= '0;
        end else begin
            kind_rec <= fire ? kind_in : rst_kind_e'(kind_rec & ~clr_kind);
            for (int k = 0; k < N_REQ; k++) begin
                req_vec[k] <= fire && (kind_in == rst_kind_e'(2'(k + 1)));
            end
        end
    end

    // R5
    one_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_vec));

    // R5
    req_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_vec) |-> (state == ST_PENDING && kind_rec != RK_NONE));

    // R5
    core_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_vec[0] |-> kind_rec == RK_CORE);

    // R3
    arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eval && state == ST_QUIET) |=> state[1]);

    // R4
    escalate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eval && state == ST_ARMED && !clr_armed) |=> state == ST_PENDING);

    // R7
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!eval && clr_armed) |=> !state[1]);

endmodule

// File: rtl/wdog_escalator.sv
module wdog_escalator
    import wdg_pkg::*;
#(
    parameter int CNT_W    = 30,
    parameter int BASE_LOG = 17,
    parameter int STEP_LOG = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tb_tick,
    input  logic        ctrl_we,
    input  logic [31:0] ctrl_wdata,
    input  logic        stat_clr_we,
    input  logic [31:0] stat_clr_data,
    output logic [31:0] status_q,
    output logic        wdog_irq,
    output logic        rst_req_core,
    output logic        rst_req_chip,
    output logic        rst_req_sys
);

    logic [1:0]       held_sel;
    logic             held_ie;
    rst_kind_e        eff_kind;
    logic             restart;
    logic             expire;
    logic             eval;
    wdg_state_e       state;
    rst_kind_e        kind_rec;
    logic [N_REQ-1:0] req_vec;
    logic             clr_armed;
    logic             clr_irqst;
    logic [1:0]       clr_kind;
    logic             unused_bits;

    assign unused_bits = ^{ctrl_wdata[POS_IE-1:0], stat_clr_data[POS_KIND-1:0]};

    assign clr_armed = stat_clr_we & stat_clr_data[POS_ARMED];
    assign clr_irqst = stat_clr_we & stat_clr_data[POS_IRQST];
    assign clr_kind  = {2{stat_clr_we}} & stat_clr_data[POS_KIND+:2];

    wdg_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ctrl_we),
        .wr_field (ctrl_wdata[WORD_W-1:POS_IE]),
        .held_sel (held_sel),
        .held_ie  (held_ie),
        .eff_kind (eff_kind),
        .restart  (restart)
    );

    wdg_period #(
        .CNT_W    (CNT_W),
        .BASE_LOG (BASE_LOG),
        .STEP_LOG (STEP_LOG)
    ) u_period (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tb_tick),
        .restart (restart),
        .sel     (held_sel),
        .expire  (expire)
    );

    // a write and an expiry in one cycle make a single step
    assign eval = restart | expire;

    wdg_escalate u_esc (
        .clk       (clk),
        .rst_n     (rst_n),
        .eval      (eval),
        .clr_armed (clr_armed),
        .clr_irqst (clr_irqst),
        .clr_kind  (clr_kind),
        .kind_in   (eff_kind),
        .state     (state),
        .kind_rec  (kind_rec),
        .req_vec   (req_vec)
    );

    assign status_q     = {state, kind_rec, {(WORD_W - 4){1'b0}}};
    assign wdog_irq     = state[0] & held_ie;
    assign rst_req_core = req_vec[0];
    assign rst_req_chip = req_vec[1];
    assign rst_req_sys  = req_vec[2];

    // R4
    irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_irq |-> status_q[POS_IRQST]);

endmodule

// File: tb/sim_wdog_escalator.sv
`timescale 1ns/1ps
module sim_wdog_escalator;

    localparam int CW = 12;
    localparam int BL = 3;
    localparam int SL = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tb_tick = 1'b0;
    logic        ctrl_we = 1'b0;
    logic [31:0] ctrl_wdata = '0;
    logic        stat_clr_we = 1'b0;
    logic [31:0] stat_clr_data = '0;
    logic [31:0] status_q;
    logic        wdog_irq;
    logic        rst_req_core;
    logic        rst_req_chip;
    logic        rst_req_sys;

    wdog_escalator #(.CNT_W(CW), .BASE_LOG(BL), .STEP_LOG(SL)) u0 (
        .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .stat_clr_we(stat_clr_we), .stat_clr_data(stat_clr_data),
        .status_q(status_q), .wdog_irq(wdog_irq),
        .rst_req_core(rst_req_core), .rst_req_chip(rst_req_chip),
        .rst_req_sys(rst_req_sys)
    );

    always #4 clk = ~clk;

    int    checks = 0;
    int    fails = 0;
    string phase = "R1";

    // behavioural reference
    int         m_ticks;
    logic [1:0] m_st, m_rsn, m_sel, m_kind;
    logic       m_ie;
    logic [2:0] m_pulse;

    task automatic model_step();
        bit         ev;
        logic [1:0] s, r;
        if (!rst_n) begin
            m_ticks = 0; m_st = 0; m_rsn = 0; m_sel = 0; m_kind = 0;
            m_ie = 0; m_pulse = 0;
            return;
        end
        ev = 0;
        if (ctrl_we) begin
            m_sel = ctrl_wdata[31:30]; m_kind = ctrl_wdata[29:28];
            m_ie = ctrl_wdata[27]; m_ticks = 0; ev = 1;
        end else if (tb_tick) begin
            m_ticks++;
            if (m_ticks == (1 << (BL + SL * m_sel))) begin
                ev = 1; m_ticks = 0;
            end
        end
        s = m_st; r = m_rsn;
        if (stat_clr_we) begin
            if (stat_clr_data[31]) s[1] = 1'b0;
            if (stat_clr_data[30]) s[0] = 1'b0;
            r = r & ~stat_clr_data[29:28];
        end
        m_pulse = 0;
        if (ev) begin
            if (s == 2'b11) begin
                r = m_kind;
                if (m_kind != 0) m_pulse[m_kind - 1] = 1'b1;
            end else if (s == 2'b10) s[0] = 1'b1;
            else s[1] = 1'b1;
        end
        m_st = s; m_rsn = r;
    endtask

    task automatic cmp(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s (phase %s) t=%0t: act=%h exp=%h", req, what, phase,
                     $time, act, exp);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        cmp("R3", "armed bit", 32'(status_q[31]), 32'(m_st[1]));
        cmp("R4", "irq status bit", 32'(status_q[30]), 32'(m_st[0]));
        cmp("R5", "recorded kind", 32'(status_q[29:28]), 32'(m_rsn));
        cmp("R5", "reset pulses", 32'({rst_req_sys, rst_req_chip, rst_req_core}),
            32'(m_pulse));
        cmp("R4", "irq output", 32'(wdog_irq), 32'(m_st[0] & m_ie));
        cmp("R1", "reserved status bits", {4'h0, status_q[27:0]}, 32'h0);
    endtask

    task automatic wr_ctrl(input int sel, input int kind, input bit ie);
        ctrl_we = 1'b1;
        ctrl_wdata = {sel[1:0], kind[1:0], ie, 27'h0};
        cycle();
        ctrl_we = 1'b0;
    endtask

    task automatic clr(input logic [3:0] bits);
        stat_clr_we = 1'b1;
        stat_clr_data = {bits, 28'h0};
        cycle();
        stat_clr_we = 1'b0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    initial begin
        // R1: reset state
        phase = "R1";
        repeat (3) cycle();
        rst_n = 1'b1;
        cycle();

        // R2: default period 8 ticks, steps QUIET->ARMED->PENDING
        phase = "R2";
        tb_tick = 1'b1;
        run(20);

        // R6: write while pending -> immediate core reset
        phase = "R6";
        wr_ctrl(0, 1, 1'b1);
        run(30);

        // R7: periodic service keeps the watchdog early
        phase = "R7";
        clr(4'hF);
        for (int k = 0; k < 10; k++) begin
            run(5);
            clr(4'hC);
        end
        // clear held across several expiries
        stat_clr_we = 1'b1;
        stat_clr_data = 32'hC000_0000;
        run(25);
        stat_clr_we = 1'b0;
        // clear only bit 31 -> FLAGGED path
        run(20);
        clr(4'h8);
        run(12);

        // R5: each reset kind
        phase = "R5";
        for (int kd = 0; kd < 4; kd++) begin
            clr(4'hF);
            wr_ctrl(0, kd, kd[0]);
            run(30);
        end

        // R2: longer periods
        phase = "R2";
        clr(4'hF);
        wr_ctrl(1, 2, 1'b1);
        run(110);
        clr(4'hF);
        wr_ctrl(2, 3, 1'b0);
        run(300);

        // R8: gaps in the tick
        phase = "R8";
        clr(4'hF);
        wr_ctrl(0, 1, 1'b1);
        for (int i = 0; i < 120; i++) begin
            tb_tick = (i % 3 == 0);
            cycle();
        end
        tb_tick = 1'b0;
        run(40);
        tb_tick = 1'b1;

        // R6: back-to-back writes with ticks running
        phase = "R6";
        run(6);
        wr_ctrl(0, 2, 1'b1);
        wr_ctrl(0, 3, 1'b1);
        wr_ctrl(0, 1, 1'b0);
        run(10);

        // mixed traffic
        phase = "R7";
        for (int i = 0; i < 4000; i++) begin
            tb_tick = ($urandom % 4) != 0;
            if ($urandom % 150 == 0) begin
                ctrl_we = 1'b1;
                ctrl_wdata = {1'b0, 1'($urandom), 2'($urandom), 1'($urandom), 27'h0};
            end
            if ($urandom % 15 == 0) begin
                stat_clr_we = 1'b1;
                stat_clr_data = {4'($urandom), 28'h0};
            end
            cycle();
            ctrl_we = 1'b0;
            stat_clr_we = 1'b0;
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL R1 watchdog expired: act=hung exp=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule